// File: doc/BRIEF.md
# Sound Generator Register Port

This block sits between a CPU byte bus and a three-channel sound generator with sixteen internal byte registers. A two-bit address selects what an access touches. Bit 1 picks either the index latch (0) or the register addressed by that latch (1). Bit 0 marks an alias of the same target. Software writes an index to the latch and then reads or writes the chosen register through the data address.

The block holds the full 8-bit index latch and the sixteen-entry register file. Bits that a register does not implement are cleared as the value is stored. An index of 16 or more blocks data access. Alias writes are honoured only for byte-size accesses. Every accepted access raises a one-cycle wait request. Writes to the fourteen sound registers are copied to a forwarding port so the synthesis engine can follow them. Read data and all other outputs are registered: they change at the clock edge that samples the strobe and are visible in the next cycle.

Register indices: 0/1, 2/3 and 4/5 are fine/coarse tone periods of channels A, B and C. 6 is the noise period and 7 the mixer. 8 to 10 are the amplitudes, 11 and 12 the envelope period, 13 the envelope shape, and 14 and 15 the two general ports.

Top module: `sndreg_iface`

## Requirements
- R1: After reset the index latch and all sixteen registers are zero, `rd_data` is 0x00, and `wait_req` and `fwd_vld` are low.
- R2: A write with address bit 1 = 0 loads the index latch; a write with bit 1 = 1 loads the register named by the latch. A read of address 0 returns that register's stored contents on `rd_data` in the cycle after the read strobe.
- R3: The index latch keeps all 8 written bits. While it holds 16 or more, data writes change no register and raise no forward strobe, and a read of address 0 returns 0xFF.
- R4: A read of address 1, 2 or 3 returns 0xFF, whatever the latch and register contents.
- R5: A write with address bit 0 = 1 takes effect only when `bus_byte` is 1. Otherwise it changes nothing and raises no wait request.
- R6: Each accepted access raises `wait_req` for exactly the one cycle after the strobe. Accepted accesses are every read, every write to addresses 0 and 2, and byte-size writes to addresses 1 and 3. A write takes precedence when both strobes are high.
- R7: Registers 1, 3, 5 and 13 store only bits 3:0, and registers 6, 8, 9 and 10 store only bits 4:0. The remaining bits are stored as zero. All other registers keep all 8 bits. The forwarded value carries the same masking.
- R8: A data write that lands in register 0 to 13 raises `fwd_vld` for one cycle, in the cycle after the strobe, with `fwd_idx` giving the register and `fwd_val` the stored value. Writes to registers 14 and 15 are not forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Bit 1: target (0 index latch, 1 data); bit 0: alias |
| bus_wdata | input | 8 | Write data |
| bus_byte | input | 1 | 1 when the bus access is byte-sized |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| rd_data | output | 8 | Registered read data |
| wait_req | output | 1 | One-cycle wait-state request |
| fwd_vld | output | 1 | Forward strobe to the sound engine |
| fwd_idx | output | 4 | Forwarded register index |
| fwd_val | output | 8 | Forwarded, masked register value |

## Verification
Every register is written with several patterns through the data address: all zeros, all ones, alternating bits and an index-derived value. Each is read back, which separates the registers' masks from one another and from the forwarding cut-off at index 14. Every index from 16 to 255 is then written, alternating between the plain address and the byte-size alias. A data write and a read follow each one, which shows that the whole latch byte is kept and tells a real block from a missed register index. Word-size alias writes are mixed with byte-size ones. The wait request and read-back show whether such a write was wrongly taken.

// File: rtl/sndreg_pkg.sv
package sndreg_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic sel_wr;    // load index latch
        logic dat_wr;    // write the indexed register (before index check)
        logic rd_sel;    // read of the plain index address
        logic rd_other;  // read of any other address
        logic accepted;  // access earns a wait state
    } bus_dec_t;

    // Bits a register really implements.
    function automatic byte_t keep_mask(input int unsigned idx);
        case (idx)
            1, 3, 5, 13:  return byte_t'(8'h0F);
            6, 8, 9, 10:  return byte_t'(8'h1F);
            default:      return '1;
        endcase
    endfunction

endpackage

// File: rtl/sndreg_decode.sv
module sndreg_decode
    import sndreg_pkg::*;
(
    input  logic [1:0] bus_addr,
    input  logic       bus_byte,
    input  logic       bus_rd,
    input  logic       bus_wr,
    output bus_dec_t   dec
);
    logic is_alias;
    logic wr_ok;
    logic rd_only;

    always_comb begin
        is_alias = bus_addr[0];
        wr_ok    = bus_wr && (!is_alias || bus_byte);
        rd_only  = bus_rd && !bus_wr;

        dec.sel_wr   = wr_ok && !bus_addr[1];
        dec.dat_wr   = wr_ok &&  bus_addr[1];
        dec.rd_sel   = rd_only && (bus_addr == 2'b00);
        dec.rd_other = rd_only && (bus_addr != 2'b00);
        dec.accepted = wr_ok || rd_only;
    end
endmodule

// File: rtl/sndreg_regfile.sv
module sndreg_regfile
    import sndreg_pkg::*;
#(
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IW-1:0]                widx,
    input  byte_t                        wval,
    output logic [NREG-1:0][DATA_W-1:0]  regs_q
);
    logic [NREG-1:0][DATA_W-1:0] regs_d;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_ent
        localparam byte_t MASK = keep_mask(gi);

        always_comb begin
            regs_d[gi] = regs_q[gi];
            if (we && (widx == IW'(gi))) begin
                regs_d[gi] = wval & MASK;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[gi] <= '0;
            end else begin
                regs_q[gi] <= regs_d[gi];
            end
        end
    end
endmodule

// File: rtl/sndreg_iface.sv
module sndreg_iface
    import sndreg_pkg::*;
#(
    parameter int NREG = 16,
    parameter int NSND = 14,
    localparam int IW  = $clog2(NREG)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_byte,
    input  logic          bus_rd,
    input  logic          bus_wr,
    output logic [7:0]    rd_data,
    output logic          wait_req,
    output logic          fwd_vld,
    output logic [IW-1:0] fwd_idx,
    output logic [7:0]    fwd_val
);
    typedef struct packed {
        byte_t         sel;
        byte_t         rdata;
        logic          wait_r;
        logic          fwd_vld;
        logic [IW-1:0] fwd_idx;
        byte_t         fwd_val;
    } state_t;

    state_t   st_d, st_q;
    bus_dec_t dec;

    logic                        sel_ok;
    logic [IW-1:0]               sel_idx;
    logic                        data_we;
    logic [NREG-1:0][DATA_W-1:0] regs_q;

    sndreg_decode u_dec (
        .bus_addr (bus_addr),
        .bus_byte (bus_byte),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .dec      (dec)
    );

    sndreg_regfile #(.NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (data_we),
        .widx   (sel_idx),
        .wval   (bus_wdata),
        .regs_q (regs_q)
    );

    always_comb begin
        sel_ok  = (st_q.sel < DATA_W'(NREG));
        sel_idx = st_q.sel[IW-1:0];
        data_we = dec.dat_wr && sel_ok;

        st_d = st_q;

        if (dec.sel_wr) begin
            st_d.sel = bus_wdata;
        end

        if (dec.rd_sel) begin
            st_d.rdata = sel_ok ? regs_q[sel_idx] : '1;
        end else if (dec.rd_other) begin
            st_d.rdata = '1;
        end

        st_d.wait_r  = dec.accepted;
        st_d.fwd_vld = data_we && (int'(sel_idx) < NSND);
        st_d.fwd_idx = sel_idx;
        st_d.fwd_val = data_we ? (bus_wdata & keep_mask(int'(sel_idx))) : st_q.fwd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdata;
    assign wait_req = st_q.wait_r;
    assign fwd_vld  = st_q.fwd_vld;
    assign fwd_idx  = st_q.fwd_idx;
    assign fwd_val  = st_q.fwd_val;
endmodule

// File: rtl/sndreg_chk.sv
module sndreg_chk
    import sndreg_pkg::*;
#(
    parameter int NSND = 14,
    parameter int IW   = 4
)(
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    bus_addr,
    input logic          bus_byte,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [7:0]    rd_data,
    input logic          wait_req,
    input logic          fwd_vld,
    input logic [IW-1:0] fwd_idx,
    input logic [7:0]    fwd_val
);
    // R6
    read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> wait_req);

    // R6
    idle_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |=> !wait_req);

    // R5
    alias_word_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0] && !bus_byte) |=> (!wait_req && !fwd_vld));

    // R4
    other_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr != 2'b00) |=> (rd_data == 8'hFF));

    // R8
    fwd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld |-> (int'(fwd_idx) < NSND));

    // R8
    fwd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld |-> $past(bus_wr && bus_addr[1]));

    // R7
    fwd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld |-> ((fwd_val & ~keep_mask(int'(fwd_idx))) == 8'h00));
endmodule

bind sndreg_iface sndreg_chk #(.NSND(NSND), .IW(IW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_byte (bus_byte),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .rd_data  (rd_data),
    .wait_req (wait_req),
    .fwd_vld  (fwd_vld),
    .fwd_idx  (fwd_idx),
    .fwd_val  (fwd_val)
);

// File: tb/sndreg_iface_bench.sv
module sndreg_iface_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_byte = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] rd_data;
    logic       wait_req;
    logic       fwd_vld;
    logic [3:0] fwd_idx;
    logic [7:0] fwd_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_reg [16];
    logic [7:0] m_sel;

    logic [7:0] s_rd;
    logic       s_wait, s_fv;
    logic [3:0] s_fi;
    logic [7:0] s_fval;

    always #2.5 clk = ~clk;

    sndreg_iface u_sndreg_iface (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_byte(bus_byte), .bus_rd(bus_rd), .bus_wr(bus_wr), .rd_data(rd_data),
        .wait_req(wait_req), .fwd_vld(fwd_vld), .fwd_idx(fwd_idx), .fwd_val(fwd_val)
    );

    function automatic logic [7:0] mask_of(input int i);
        if (i == 13 || (i < 6 && (i % 2) == 1)) return 8'h0F;
        if (i == 6 || (i >= 8 && i <= 10))       return 8'h1F;
        return 8'hFF;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic r, input logic w, input logic [1:0] a,
                       input logic b, input logic [7:0] d);
        @(negedge clk);
        bus_rd = r; bus_wr = w; bus_addr = a; bus_byte = b; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        s_rd = rd_data; s_wait = wait_req; s_fv = fwd_vld; s_fi = fwd_idx; s_fval = fwd_val;
    endtask

    // Write the index latch through the plain address and check the wait.
    task automatic put_sel(input logic [7:0] s);
        acc(1'b0, 1'b1, 2'd0, 1'b0, s);
        m_sel = s;
        chk(s_wait == 1'b1, "R6 select write wait", s_wait, 1);
        chk(s_fv == 1'b0, "R8 no forward on select write", s_fv, 0);
    endtask

    task automatic put_data(input logic [1:0] a, input logic b, input logic [7:0] v);
        bit take, fw;
        logic [7:0] mv;
        acc(1'b0, 1'b1, a, b, v);
        take = !a[0] || b;
        fw   = take && (m_sel < 16) && (m_sel < 14);
        mv   = v & mask_of(int'(m_sel[3:0]));
        if (take && m_sel < 16) m_reg[m_sel[3:0]] = mv;
        chk(s_wait == take, take ? "R6 data write wait" : "R5 word alias no wait", s_wait, int'(take));
        chk(s_fv == fw, m_sel >= 16 ? "R3 no forward when index high" : "R8 forward strobe", s_fv, int'(fw));
        if (fw) begin
            chk(s_fi == m_sel[3:0], "R8 forward index", s_fi, m_sel[3:0]);
            chk(s_fval == mv, "R7 forward value masked", s_fval, mv);
        end
    endtask

    task automatic read_sel(input string req);
        logic [7:0] e;
        acc(1'b1, 1'b0, 2'd0, 1'b0, 8'h00);
        e = (m_sel < 16) ? m_reg[m_sel[3:0]] : 8'hFF;
        chk(s_rd == e, req, s_rd, e);
        chk(s_wait == 1'b1, "R6 read wait", s_wait, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
        m_sel = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h00, "R1 reset read data", rd_data, 0);
        chk(wait_req == 1'b0, "R1 reset wait", wait_req, 0);
        chk(fwd_vld == 1'b0, "R1 reset forward", fwd_vld, 0);
        for (int i = 0; i < 16; i++) begin
            put_sel(8'(i));
            read_sel("R1 register zero after reset");
        end

        // R2 R7 R8: every register, several patterns
        for (int i = 0; i < 16; i++) begin
            for (int p = 0; p < 5; p++) begin
                logic [7:0] v;
                case (p)
                    0: v = 8'h00;
                    1: v = 8'hFF;
                    2: v = 8'hA5;
                    3: v = 8'h5A;
                    default: v = 8'((i * 37 + 11) & 255);
                endcase
                put_sel(8'(i));
                put_data(2'd2, 1'b0, v);
                read_sel("R2 R7 read back masked");
            end
        end

        // R4: other addresses read all ones
        put_sel(8'd7);
        for (int a = 1; a < 4; a++) begin
            acc(1'b1, 1'b0, 2'(a), 1'b1, 8'h00);
            chk(s_rd == 8'hFF, "R4 non-select read", s_rd, 8'hFF);
            chk(s_wait == 1'b1, "R6 read wait", s_wait, 1);
        end

        // R3: every index of 16 and above
        for (int s = 16; s < 256; s++) begin
            if (s % 2 == 0) begin
                put_sel(8'(s));
            end else begin
                acc(1'b0, 1'b1, 2'd1, 1'b1, 8'(s));
                m_sel = 8'(s);
                chk(s_wait == 1'b1, "R5 byte alias select wait", s_wait, 1);
            end
            put_data(2'(2 + (s % 2)), 1'b1, 8'h3C);
            read_sel("R3 high index reads all ones");
            put_sel(8'(s % 16));
            read_sel("R3 register untouched by high index");
        end

        // R5: word-size alias writes ignored, byte-size taken
        put_sel(8'd4);
        acc(1'b0, 1'b1, 2'd1, 1'b0, 8'd9);
        chk(s_wait == 1'b0, "R5 word alias select no wait", s_wait, 0);
        read_sel("R5 select unchanged by word alias");
        put_data(2'd3, 1'b0, 8'h77);
        read_sel("R5 register unchanged by word alias");
        put_data(2'd3, 1'b1, 8'h77);
        read_sel("R5 byte alias data write taken");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule